// File: doc/BRIEF.md
# E1 Channel Timing and Blocking Generator

This block runs on the 2.048 MHz bit clock of an E1 stream and keeps track of where the current bit sits in the frame. Each 125 µs frame has 32 eight-bit time slots, and slot 0 comes first. Within a slot the bits go out most significant first. Frames are grouped into multiframes of 16. From one shared position counter the block produces four outputs:

- a channel clock that is high during the least significant bit of every slot;
- a one-clock frame sync;
- a one-clock multiframe sync;
- a channel-block level for the slot in progress.

The channel-block level is taken from a 32-bit mask, one bit per slot. Downstream logic uses it to gate serial controllers in fractional E1 services, or to pick out slots for drop-and-insert. The mask arrives as a parallel input. It is captured only at frame boundaries, so a slot is never partly blocked.

An optional external sync input realigns the counters. When the input is enabled and a pulse is seen, the next bit becomes the first bit of slot 0 of frame 0. Without a pulse the counters free-run.

Top module: `e1_chan_timing`

## Requirements
- R1: While reset is held low, and in the first cycle after its release, the position is frame 0, slot 0, bit 0. In that position `frame_sync` and `mframe_sync` are 1 and `chan_blk` is 0, because the captured mask resets to all zeros.
- R2: With no sync, each clock advances `bit_idx` through 0..7. `slot_idx` advances through 0..31 when `bit_idx` wraps from 7, and `frame_idx` advances through 0..15 when `slot_idx` wraps from 31.
- R3: `chan_clk` is 1 exactly when `bit_idx` is 7. Index 0 is the first (most significant) bit of the slot and index 7 is the least significant.
- R4: `frame_sync` is 1 exactly when `slot_idx` is 0 and `bit_idx` is 0. With no sync this is once every 256 clocks.
- R5: `mframe_sync` is 1 exactly when `frame_sync` is 1 and `frame_idx` is 0. With no sync this is once every 4096 clocks.
- R6: During slot s, `chan_blk` equals bit s of the captured mask. Mask bit 0 belongs to slot 0.
- R7: `blk_mask` is captured on the clock edge that moves the position from slot 31, bit 7 to slot 0, bit 0, and on a sync reload. A change of `blk_mask` at any other time has no effect on `chan_blk` until the next capture.
- R8: When `sync_en` and `sync_in` are both 1 at a clock edge, the next position is frame 0, slot 0, bit 0, and `blk_mask` is captured at that same edge.
- R9: When `sync_en` is 0, `sync_in` has no effect on the position or on the captured mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_en | input | 1 | Enables realignment from `sync_in` |
| sync_in | input | 1 | External boundary pulse |
| blk_mask | input | 32 | Per-slot block levels; bit s belongs to slot s |
| chan_clk | output | 1 | High during bit 7 (least significant) of each slot |
| chan_blk | output | 1 | Block level for the current slot |
| frame_sync | output | 1 | High on bit 0 of slot 0 |
| mframe_sync | output | 1 | High on bit 0 of slot 0 of frame 0 |
| slot_idx | output | 5 | Current time slot, 0..31 |
| bit_idx | output | 3 | Current bit in the slot, 0 = most significant |
| frame_idx | output | 4 | Current frame in the multiframe, 0..15 |

## Verification
A free-running stretch longer than two multiframes shows the counter wraps and the pulse spacing: exactly one multiframe sync per 4096 clocks, and one frame sync per 256.

Directed cases cover three points:

- A mask that flips from all zeros to all ones in the middle of a frame separates capture at the boundary from capture at any other edge.
- A sync pulse in mid-frame separates a reload from a free run.
- A pulse held with the enable low must leave the position untouched.

A seeded random run with rare sync pulses and frequent mask changes follows. It compares every output in every cycle against a bench model, which catches off-by-one errors in the wrap points and in the capture timing.

// File: rtl/e1t_pkg.sv
// Package e1t_pkg
// Default frame geometry shared by the channel timing modules.
// Assumes a frame of slots of bits, grouped into multiframes.
package e1t_pkg;
    localparam int unsigned DEF_SLOTS  = 32;
    localparam int unsigned DEF_BITS   = 8;
    localparam int unsigned DEF_FRAMES = 16;
endpackage

// File: rtl/e1t_position_ctr.sv
// Module e1t_position_ctr
// Keeps the bit, slot and frame position of the stream. Reloads all
// three to zero on an enabled sync pulse. Flags the edges on which the
// block mask must be captured. Assumes each count is at least 2.
module e1t_position_ctr #(
    parameter int unsigned SLOTS  = e1t_pkg::DEF_SLOTS,
    parameter int unsigned BITS   = e1t_pkg::DEF_BITS,
    parameter int unsigned FRAMES = e1t_pkg::DEF_FRAMES,
    localparam int unsigned SLOT_W  = $clog2(SLOTS),
    localparam int unsigned BIT_W   = $clog2(BITS),
    localparam int unsigned FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_hit_i,
    output logic [SLOT_W-1:0]  slot_o,
    output logic [BIT_W-1:0]   bit_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               load_o
);
    logic [SLOT_W-1:0]  slot_q;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] frame_q;
    logic bit_last, slot_last, frame_last;

    // Wrap points of each counter level.
    always_comb begin
        bit_last   = (bit_q   == BIT_W'(BITS - 1));
        slot_last  = (slot_q  == SLOT_W'(SLOTS - 1));
        frame_last = (frame_q == FRAME_W'(FRAMES - 1));
        load_o     = sync_hit_i | (bit_last & slot_last);
    end

    // Cascaded position counters with sync reload.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_hit_i) begin
            bit_q   <= '0;
            slot_q  <= '0;
            frame_q <= '0;
        end else begin
            bit_q <= bit_last ? '0 : bit_q + 1'b1;
            if (bit_last) begin
                slot_q <= slot_last ? '0 : slot_q + 1'b1;
                if (slot_last) begin
                    frame_q <= frame_last ? '0 : frame_q + 1'b1;
                end
            end
        end
    end

    assign slot_o  = slot_q;
    assign bit_o   = bit_q;
    assign frame_o = frame_q;

    // R8: an enabled sync pulse zeroes the whole position.
    p_sync_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_i |=> (bit_q == '0 && slot_q == '0 && frame_q == '0));

    // R2: the slot holds while the bit counter is inside a slot.
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_hit_i && bit_q != BIT_W'(BITS - 1)) |=> $stable(slot_q));

    // R2: the frame holds except at the last bit of the last slot.
    p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o) |=> $stable(frame_q));
endmodule

// File: rtl/e1t_mask_gate.sv
// Module e1t_mask_gate
// Holds the captured per-slot block mask and selects the level for the
// current slot. Capture happens only when load_i is high. Assumes
// SLOTS is a power of two, so every slot index is in range.
module e1t_mask_gate #(
    parameter int unsigned SLOTS = e1t_pkg::DEF_SLOTS,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SLOTS-1:0]  mask_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              blk_o
);
    logic [SLOTS-1:0] active_q;

    // Frame-aligned capture of the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load_i) begin
            active_q <= mask_i;
        end
    end

    // Per-slot selection of the block level.
    always_comb begin
        blk_o = active_q[slot_i];
    end

    // R7: the captured mask changes only on a capture edge.
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(active_q));
endmodule

// File: rtl/e1t_pulse_dec.sv
// Module e1t_pulse_dec
// Decodes the position into the channel clock, the frame sync and the
// multiframe sync. Purely combinational.
module e1t_pulse_dec #(
    parameter int unsigned SLOTS  = e1t_pkg::DEF_SLOTS,
    parameter int unsigned BITS   = e1t_pkg::DEF_BITS,
    parameter int unsigned FRAMES = e1t_pkg::DEF_FRAMES,
    localparam int unsigned SLOT_W  = $clog2(SLOTS),
    localparam int unsigned BIT_W   = $clog2(BITS),
    localparam int unsigned FRAME_W = $clog2(FRAMES)
) (
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [BIT_W-1:0]   bit_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               chan_clk_o,
    output logic               fsync_o,
    output logic               mfsync_o
);
    // Position decode for the three timing strobes.
    always_comb begin
        chan_clk_o = (bit_i == BIT_W'(BITS - 1));
        fsync_o    = (bit_i == '0) && (slot_i == '0);
        mfsync_o   = fsync_o && (frame_i == '0);
    end
endmodule

// File: rtl/e1_chan_timing.sv
// Module e1_chan_timing
// Top of the channel timing generator. It drives the per-slot channel
// clock, the masked channel-block level, and the frame and multiframe
// syncs from one shared position counter. An enabled sync input
// realigns the counter. Assumes clk is the bit clock.
module e1_chan_timing #(
    parameter int unsigned SLOTS  = e1t_pkg::DEF_SLOTS,
    parameter int unsigned BITS   = e1t_pkg::DEF_BITS,
    parameter int unsigned FRAMES = e1t_pkg::DEF_FRAMES,
    localparam int unsigned SLOT_W  = $clog2(SLOTS),
    localparam int unsigned BIT_W   = $clog2(BITS),
    localparam int unsigned FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_en,
    input  logic               sync_in,
    input  logic [SLOTS-1:0]   blk_mask,
    output logic               chan_clk,
    output logic               chan_blk,
    output logic               frame_sync,
    output logic               mframe_sync,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic [BIT_W-1:0]   bit_idx,
    output logic [FRAME_W-1:0] frame_idx
);
    logic sync_hit;
    logic load;

    // Qualify the external boundary pulse with its enable.
    always_comb begin
        sync_hit = sync_en & sync_in;
    end

    e1t_position_ctr #(.SLOTS(SLOTS), .BITS(BITS), .FRAMES(FRAMES)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_hit_i (sync_hit),
        .slot_o     (slot_idx),
        .bit_o      (bit_idx),
        .frame_o    (frame_idx),
        .load_o     (load)
    );

    e1t_mask_gate #(.SLOTS(SLOTS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .mask_i (blk_mask),
        .slot_i (slot_idx),
        .blk_o  (chan_blk)
    );

    e1t_pulse_dec #(.SLOTS(SLOTS), .BITS(BITS), .FRAMES(FRAMES)) u_dec (
        .slot_i     (slot_idx),
        .bit_i      (bit_idx),
        .frame_i    (frame_idx),
        .chan_clk_o (chan_clk),
        .fsync_o    (frame_sync),
        .mfsync_o   (mframe_sync)
    );

    // R3: the channel clock is a single-cycle strobe.
    p_chclk_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |=> !chan_clk);

    // R4: without a reload the frame sync lasts one clock.
    p_fsync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !sync_hit) |=> !frame_sync);

    // R5: the multiframe sync only occurs together with a frame sync.
    p_mfsync_in_fs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_sync |-> frame_sync);

    // R4: the last bit of a frame is followed by a frame sync.
    p_fsync_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_clk && slot_idx == SLOT_W'(SLOTS - 1)) |=> frame_sync);
endmodule

// File: tb/e1_chan_timing_tb.sv
// Bench for e1_chan_timing. A cycle model in the bench predicts every
// output. Directed corner cases come first, then seeded random stimulus.
module e1_chan_timing_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_en = 1'b0;
    logic        sync_in = 1'b0;
    logic [31:0] blk_mask = '0;
    logic        chan_clk, chan_blk, frame_sync, mframe_sync;
    logic [4:0]  slot_idx;
    logic [2:0]  bit_idx;
    logic [3:0]  frame_idx;

    int n_vec  = 0;
    int n_fail = 0;
    int m_bit = 0, m_slot = 0, m_frame = 0;
    logic [31:0] m_mask = '0;
    logic [31:0] cur_mask = '0;
    int mf_count = 0;

    always #2 clk = ~clk;

    e1_chan_timing dut_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .sync_in(sync_in),
        .blk_mask(blk_mask), .chan_clk(chan_clk), .chan_blk(chan_blk),
        .frame_sync(frame_sync), .mframe_sync(mframe_sync),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_idx(frame_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_fs();
        return (m_bit == 0) && (m_slot == 0);
    endfunction

    // Compare every output against the model position.
    task automatic compare_all();
        check(bit_idx == m_bit, "R2 bit_idx", bit_idx, m_bit);
        check(slot_idx == m_slot, "R2 slot_idx", slot_idx, m_slot);
        check(frame_idx == m_frame, "R2 frame_idx", frame_idx, m_frame);
        check(chan_clk == (m_bit == 7), "R3 chan_clk", chan_clk, m_bit == 7);
        check(frame_sync == exp_fs(), "R4 frame_sync", frame_sync, exp_fs());
        check(mframe_sync == (exp_fs() && m_frame == 0), "R5 mframe_sync",
              mframe_sync, exp_fs() && m_frame == 0);
        check(chan_blk == m_mask[m_slot], "R6 chan_blk", chan_blk, m_mask[m_slot]);
        if (mframe_sync) mf_count++;
    endtask

    // Model of one clock edge given the inputs applied before it.
    task automatic step_model(input bit hit, input logic [31:0] mk);
        if (hit) begin
            m_bit = 0; m_slot = 0; m_frame = 0; m_mask = mk;
        end else begin
            if (m_bit == 7 && m_slot == 31) m_mask = mk;
            if (m_bit == 7) begin
                m_bit = 0;
                if (m_slot == 31) begin
                    m_slot = 0;
                    m_frame = (m_frame + 1) % 16;
                end else m_slot++;
            end else m_bit++;
        end
    endtask

    task automatic run_cycle(input bit en, input bit si, input logic [31:0] mk);
        compare_all();
        sync_en = en; sync_in = si; blk_mask = mk; cur_mask = mk;
        step_model(en && si, mk);
        @(negedge clk);
    endtask

    task automatic run_to(input int slot, input int bitn);
        while (!(m_slot == slot && m_bit == bitn)) run_cycle(1'b0, 1'b0, cur_mask);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        blk_mask = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        // R1: reset state, even with a non-zero mask applied.
        check(slot_idx == 0 && bit_idx == 0 && frame_idx == 0, "R1 position",
              {frame_idx, slot_idx, bit_idx}, 0);
        check(frame_sync && mframe_sync, "R1 syncs", {frame_sync, mframe_sync}, 3);
        check(chan_blk == 1'b0, "R1 chan_blk", chan_blk, 0);
        cur_mask = '0; blk_mask = '0;
        rst_n = 1'b1;

        // R7: a mid-frame mask change waits for the boundary.
        run_cycle(1'b0, 1'b0, 32'h0);
        run_to(10, 3);
        run_cycle(1'b0, 1'b0, 32'hFFFF_FFFF);
        run_to(20, 2);
        check(chan_blk == 1'b0, "R7 old mask kept", chan_blk, 0);
        run_to(31, 7);
        check(chan_blk == 1'b0, "R7 old mask at last bit", chan_blk, 0);
        run_cycle(1'b0, 1'b0, cur_mask);
        check(chan_blk == 1'b1, "R7 new mask after boundary", chan_blk, 1);

        // R8: a sync in mid-frame reloads the position and captures the mask.
        run_to(13, 5);
        run_cycle(1'b1, 1'b1, 32'h0000_0002);
        check(slot_idx == 0 && bit_idx == 0 && frame_idx == 0, "R8 reload",
              {frame_idx, slot_idx, bit_idx}, 0);
        check(chan_blk == 1'b0, "R8 mask slot0", chan_blk, 0);
        run_to(1, 0);
        check(chan_blk == 1'b1, "R8 mask slot1", chan_blk, 1);

        // R9: a disabled sync input is ignored.
        run_to(6, 2);
        for (int i = 0; i < 40; i++) run_cycle(1'b0, 1'b1, cur_mask);
        check(slot_idx == 11 && bit_idx == 2, "R9 no reload",
              {slot_idx, bit_idx}, {5'd11, 3'd2});
        check(chan_blk == 1'b0, "R9 mask untouched", chan_blk, 0);
        run_cycle(1'b0, 1'b0, cur_mask);

        // R5: free run over two multiframes.
        run_to(0, 1);
        mf_count = 0;
        for (int i = 0; i < 8192; i++) run_cycle(1'b0, 1'b0, cur_mask);
        check(mf_count == 2, "R5 multiframe count", mf_count, 2);

        // Seeded random: rare sync pulses, frequent mask changes.
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] mk;
            bit en, si;
            mk = ($urandom % 40 == 0) ? $urandom : cur_mask;
            en = ($urandom % 4 != 0);
            si = ($urandom % 300 == 0);
            run_cycle(en, si, mk);
        end
        compare_all();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule